// File: doc/BRIEF.md
# Burst Receiver Enable and Sequencing Controller

This block governs the receive side of a burst-mode spread-spectrum receiver. It combines a software enable bit with an external enable pin into a single receiver enable. When that enable drops, a fixed multi-cycle clear sequence runs. While the sequence runs and while the receiver is off, the receive datapaths are held clear.

Each burst begins when an upstream correlator reports a detected preamble. The controller then moves from acquisition to data mode. It counts data-symbol strobes against a programmed 16-bit burst length and returns to acquisition as soon as the burst is complete. Any later re-enable also leaves the controller in acquisition.

The block also holds a small test-point select register that the host can write. The clear sequence wipes this register.

Top module: `rx_burst_ctrl`

## Requirements
- R1: The effective enable is `cfg_rx_en OR pin_rx_en`. `rx_active` is high one clock after the effective enable is high, provided no clear sequence is running.
- R2: A clear sequence starts on the first clock edge that samples the effective enable low after it was high. `rst_busy` is then high for exactly RST_CYCLES (default 6) clocks. `dp_clear` is high whenever `rx_active` is low.
- R3: On a `tsel_wr` pulse, the 4-bit `tsel` register loads `tsel_wdata`. The clear sequence sets `tsel` to 0, and writes made while `rst_busy` is high are ignored.
- R4: After a clear sequence and a re-enable, the controller is in acquisition mode (`acq_mode`=1, `data_mode`=0) with `sym_count`=0, whatever mode it was in before.
- R5: In acquisition mode with `rx_active` high, a `preamble_det` pulse moves the controller to data mode on the next clock and sets `sym_count` to 0.
- R6: In data mode, each `sym_stb` adds 1 to `sym_count`. Let N = `{len_hi,len_lo}` − 2. On the strobe that brings the count to N, the controller returns to acquisition at that same edge and raises `burst_end` for one clock. `sym_count` keeps N until the next preamble.
- R7: A programmed length below 3 (outside the legal range of 3 to 65535) is treated as a burst of one symbol.
- R8: `sym_stb` has no effect on `sym_count` outside data mode, and `preamble_det` has no effect while in data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx_en | input | 1 | Software receiver enable bit |
| pin_rx_en | input | 1 | External receiver enable pin |
| len_lo | input | 8 | Burst length, low byte |
| len_hi | input | 8 | Burst length, high byte |
| tsel_wr | input | 1 | Test-select write strobe |
| tsel_wdata | input | 4 | Test-select write data |
| preamble_det | input | 1 | Preamble detected by the correlator |
| sym_stb | input | 1 | One pulse per received data symbol |
| rx_active | output | 1 | Receiver enabled and not clearing |
| rst_busy | output | 1 | Clear sequence in progress |
| dp_clear | output | 1 | Hold receive datapaths clear |
| acq_mode | output | 1 | Controller in acquisition mode |
| data_mode | output | 1 | Controller in data mode |
| sym_count | output | 16 | Data symbols counted in the current or last burst |
| burst_end | output | 1 | One-clock pulse when a burst completes |
| tsel | output | 4 | Test-point select |

## Verification
The bench builds the block with its default parameters: a 16-bit length and a six-cycle clear sequence. With these values, the exact length of the busy window can be measured cycle by cycle. Short programmed lengths (0, 2, 3, 4, 5, 6) reach the minimum-burst clamp, both spaced and back-to-back strobes, and a power-down that happens in the middle of a burst. Lengths near 65535 use the same compare path but are not driven, to keep the run short.

// File: rtl/rxb_pkg.sv
// Shared types for the burst receiver controller.
package rxb_pkg;
    typedef enum logic {
        MODE_ACQ  = 1'b0,
        MODE_DATA = 1'b1
    } rx_mode_e;
endpackage

// File: rtl/rxb_enable_seq.sv
// Combines the two enable sources and runs the fixed-length clear sequence.
// Assumes both enable inputs are synchronous to clk.
module rxb_enable_seq #(
    parameter int RST_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic pin_en,
    output logic seq_start,
    output logic rx_active,
    output logic rst_busy,
    output logic clr
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic          en_eff;
    logic          en_q;
    logic [CW-1:0] cnt_q;

    assign en_eff    = cfg_en | pin_en;
    assign seq_start = en_q & ~en_eff;
    assign rst_busy  = (cnt_q != '0);
    assign rx_active = en_q & ~rst_busy;
    assign clr       = ~rx_active | ~en_eff;

    // Remember the previous effective enable so a falling edge can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_eff;
    end

    // Load the sequence length on a falling enable, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (seq_start)  cnt_q <= CW'(RST_CYCLES);
        else if (rst_busy)   cnt_q <= cnt_q - 1'b1;
    end

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !en_eff) |=> rst_busy);
    // R1
    active_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> $past(cfg_en | pin_en));
endmodule

// File: rtl/rxb_test_sel.sv
// Host-writable test-point select register, wiped by the clear sequence.
// Assumes clear_req covers the whole clear window, including its first edge.
module rxb_test_sel #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_req,
    input  logic         rst_busy,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sel
);
    // Clearing wins over host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel <= '0;
        else if (clear_req) sel <= '0;
        else if (wr)        sel <= wdata;
    end

    // R3
    tsel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> (sel == '0));
endmodule

// File: rtl/rxb_burst_fsm.sv
// Acquisition/data mode tracker and burst symbol counter.
// Assumes clr is high whenever the receiver is not active.
module rxb_burst_fsm
    import rxb_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rst_busy,
    input  logic             preamble,
    input  logic             sym_stb,
    input  logic [LEN_W-1:0] len,
    output rx_mode_e         mode,
    output logic [LEN_W-1:0] cnt,
    output logic             burst_end
);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(3);

    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] cnt_nxt;

    // Symbols per burst: programmed value minus two, never below one.
    always_comb begin
        limit   = (len < MIN_LEN) ? LEN_W'(1) : (len - LEN_W'(2));
        cnt_nxt = cnt + 1'b1;
    end

    // Mode transitions, symbol counting and the end-of-burst pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_ACQ;
            cnt       <= '0;
            burst_end <= 1'b0;
        end else begin
            burst_end <= 1'b0;
            if (clr) begin
                mode <= MODE_ACQ;
                cnt  <= '0;
            end else begin
                case (mode)
                    MODE_ACQ: if (preamble) begin
                        mode <= MODE_DATA;
                        cnt  <= '0;
                    end
                    MODE_DATA: if (sym_stb) begin
                        cnt <= cnt_nxt;
                        if (cnt_nxt >= limit) begin
                            mode      <= MODE_ACQ;
                            burst_end <= 1'b1;
                        end
                    end
                    default: mode <= MODE_ACQ;
                endcase
            end
        end
    end

    // R4
    busy_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> (mode == MODE_ACQ && cnt == '0));
    // R6
    cnt_below_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA) |-> (cnt < limit));
    // R8
    acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACQ && !preamble && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rx_burst_ctrl.sv
// Top level: receiver enable, clear sequence, burst tracking and test select.
// Assumes all inputs are synchronous to clk.
module rx_burst_ctrl
    import rxb_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int RST_CYCLES = 6,
    parameter int TSEL_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              pin_rx_en,
    input  logic [7:0]        len_lo,
    input  logic [7:0]        len_hi,
    input  logic              tsel_wr,
    input  logic [TSEL_W-1:0] tsel_wdata,
    input  logic              preamble_det,
    input  logic              sym_stb,
    output logic              rx_active,
    output logic              rst_busy,
    output logic              dp_clear,
    output logic              acq_mode,
    output logic              data_mode,
    output logic [LEN_W-1:0]  sym_count,
    output logic              burst_end,
    output logic [TSEL_W-1:0] tsel
);
    logic     seq_start;
    logic     clr;
    rx_mode_e mode;
    logic [LEN_W-1:0] len;

    assign len       = LEN_W'({len_hi, len_lo});
    assign dp_clear  = ~rx_active;
    assign acq_mode  = (mode == MODE_ACQ);
    assign data_mode = (mode == MODE_DATA);

    rxb_enable_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_rx_en),
        .pin_en    (pin_rx_en),
        .seq_start (seq_start),
        .rx_active (rx_active),
        .rst_busy  (rst_busy),
        .clr       (clr)
    );

    rxb_test_sel #(.W(TSEL_W)) u_tsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (seq_start | rst_busy),
        .rst_busy  (rst_busy),
        .wr        (tsel_wr),
        .wdata     (tsel_wdata),
        .sel       (tsel)
    );

    rxb_burst_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rst_busy  (rst_busy),
        .preamble  (preamble_det),
        .sym_stb   (sym_stb),
        .len       (len),
        .mode      (mode),
        .cnt       (sym_count),
        .burst_end (burst_end)
    );

    // R6
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> acq_mode);
endmodule

// File: tb/rx_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_burst_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rx_en = 1'b0, pin_rx_en = 1'b0;
    logic [7:0]  len_lo = '0, len_hi = '0;
    logic        tsel_wr = 1'b0;
    logic [3:0]  tsel_wdata = '0;
    logic        preamble_det = 1'b0, sym_stb = 1'b0;
    logic        rx_active, rst_busy, dp_clear, acq_mode, data_mode, burst_end;
    logic [15:0] sym_count;
    logic [3:0]  tsel;

    int total = 0;
    int bad = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    rx_burst_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .pin_rx_en(pin_rx_en),
        .len_lo(len_lo), .len_hi(len_hi), .tsel_wr(tsel_wr), .tsel_wdata(tsel_wdata),
        .preamble_det(preamble_det), .sym_stb(sym_stb), .rx_active(rx_active),
        .rst_busy(rst_busy), .dp_clear(dp_clear), .acq_mode(acq_mode),
        .data_mode(data_mode), .sym_count(sym_count), .burst_end(burst_end), .tsel(tsel)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: every end-of-burst pulse must match the next expected length.
    always @(posedge clk) begin
        #1;
        if (rst_n && burst_end) begin
            if (exp_q.size() == 0) chk("R6 unexpected burst_end", 1, 0);
            else chk("R6 scoreboard burst length", int'(sym_count), exp_q.pop_front());
        end
    end

    // Driver: runs one complete burst and queues the expected symbol count.
    task automatic run_burst(input logic [15:0] len, input int lim, input bit b2b);
        {len_hi, len_lo} = len;
        exp_q.push_back(lim);
        preamble_det = 1'b1;
        step();
        preamble_det = 1'b0;
        chk("R5 data mode after preamble", int'(data_mode), 1);
        chk("R5 count cleared", int'(sym_count), 0);
        for (int i = 1; i <= lim; i++) begin
            sym_stb = 1'b1;
            step();
            if (!b2b) sym_stb = 1'b0;
            if (i < lim) begin
                chk("R6 count increments", int'(sym_count), i);
                chk("R6 still data mode", int'(data_mode), 1);
                if (!b2b && i == 1) begin
                    preamble_det = 1'b1;
                    step();
                    preamble_det = 1'b0;
                    chk("R8 preamble ignored in data mode", int'(sym_count), 1);
                end
            end
        end
        sym_stb = 1'b0;
        chk("R6 back to acquisition", int'(acq_mode), 1);
        chk("R6 burst_end pulse", int'(burst_end), 1);
        step();
        chk("R6 burst_end one cycle", int'(burst_end), 0);
        chk("R6 count holds", int'(sym_count), lim);
    endtask

    initial begin
        int busy_n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2 reset rx_active", int'(rx_active), 0);
        chk("R2 reset dp_clear", int'(dp_clear), 1);
        chk("R4 reset acq_mode", int'(acq_mode), 1);
        chk("R3 reset tsel", int'(tsel), 0);

        // R1: pin alone, then register bit alone
        pin_rx_en = 1'b1;
        step();
        chk("R1 pin enables", int'(rx_active), 1);
        chk("R2 dp_clear released", int'(dp_clear), 0);
        pin_rx_en = 1'b0; cfg_rx_en = 1'b1;
        step();
        chk("R1 register bit enables", int'(rx_active), 1);

        // R3 write
        tsel_wr = 1'b1; tsel_wdata = 4'd9;
        step();
        tsel_wr = 1'b0;
        chk("R3 tsel write", int'(tsel), 9);

        // R8 strobes in acquisition
        sym_stb = 1'b1;
        repeat (2) step();
        sym_stb = 1'b0;
        chk("R8 strobe ignored in acq", int'(sym_count), 0);
        chk("R8 still acq", int'(acq_mode), 1);

        run_burst(16'd5, 3, 1'b0);
        run_burst(16'd3, 1, 1'b0);
        run_burst(16'd0, 1, 1'b0);  // R7
        run_burst(16'd2, 1, 1'b0);  // R7
        run_burst(16'd6, 4, 1'b1);

        // R2/R3/R4: power-down mid-burst
        {len_hi, len_lo} = 16'd10;
        preamble_det = 1'b1; step(); preamble_det = 1'b0;
        sym_stb = 1'b1; repeat (2) step(); sym_stb = 1'b0;
        chk("R5 mid-burst count", int'(sym_count), 2);
        tsel_wr = 1'b1; tsel_wdata = 4'd7; step(); tsel_wr = 1'b0;
        cfg_rx_en = 1'b0;
        step();
        chk("R2 busy starts", int'(rst_busy), 1);
        chk("R3 tsel cleared", int'(tsel), 0);
        chk("R4 forced acq", int'(acq_mode), 1);
        busy_n = 1;
        for (int k = 0; k < 20; k++) begin
            if (k == 0) begin tsel_wr = 1'b1; tsel_wdata = 4'd3; end
            step();
            tsel_wr = 1'b0;
            if (k == 0) chk("R3 write ignored while busy", int'(tsel), 0);
            if (rst_busy) busy_n++;
            else break;
        end
        chk("R2 busy length", busy_n, 6);
        chk("R2 dp_clear while off", int'(dp_clear), 1);
        pin_rx_en = 1'b1;
        step();
        chk("R4 re-enable active", int'(rx_active), 1);
        chk("R4 acq after re-enable", int'(acq_mode), 1);
        chk("R4 not data", int'(data_mode), 0);
        chk("R4 count zero", int'(sym_count), 0);
        chk("R3 tsel stays zero", int'(tsel), 0);

        run_burst(16'd4, 2, 1'b0);
        step();
        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule